// File: doc/BRIEF.md
# Bipolar Stepper Phase Sequencer

This block generates the terminal drive pattern for a two-coil bipolar stepper motor. A step input is sampled in the system clock domain. Each rising edge of that input moves an internal position by one step. A direction input selects clockwise or counter-clockwise travel. A mode input selects either four-phase full stepping or eight-phase half stepping.

The outputs give four high-side enables and four low-side enables, one pair for each coil terminal, together with the current position index. During the intermediate half-step positions, one coil is left unpowered. An impedance-control input decides how that idle coil is treated: it can float, or both of its terminals can be pulled to the high side. A synchronous home input returns the sequencer to its first phase.

The position is held in half-step units, from 0 to 7. Full stepping uses the even values. Odd values are the intermediate half steps.

Top module: `step_seq_top`

## Requirements
- R1: After the asynchronous reset `rst_ni` is released, `phase_o` is 0, `hs_o` is 4'b0101 and `ls_o` is 4'b1010.
- R2: A rising edge on `step_i` moves the position exactly once, `SYNC_STAGES`+1 clock edges after it is first sampled. Holding `step_i` high or low does not move the position.
- R3: When `dir_i`=1 (clockwise), the index increases modulo 8. When `dir_i`=0 (counter-clockwise), it decreases modulo 8.
- R4: When `half_i`=0 and the index is even, each step moves the index by 2, so it stays on even values.
- R5: When `half_i`=1, each step moves the index by 1.
- R6: When `half_i`=0 and the index is odd (left over from a mode change), the next step moves the index by 1. This lands on the next even index in the selected direction.
- R7: Terminals 0 and 1 belong to coil 1, and terminals 2 and 3 to coil 2. Bit n of `hs_o` and `ls_o` is terminal n. A coil driven "+" has its first terminal high-side on and its second terminal low-side on; "−" is the reverse. The even indices 0, 2, 4 and 6 drive coil1/coil2 as +/+, −/+, −/−, +/− respectively.
- R8: At the odd indices, only one coil is driven. Index 1 drives coil 2 "+", index 3 drives coil 1 "−", index 5 drives coil 2 "−" and index 7 drives coil 1 "+". The other coil is idle.
- R9: With `hold_idle_i`=0, both terminals of the idle coil have their high side and low side off. With `hold_idle_i`=1, both terminals have the high side on and the low side off.
- R10: No terminal ever has its high side and low side on at the same time.
- R11: With `set_i`=1 at a clock edge, the index becomes 0 at that edge. This takes priority over a step arriving at the same edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| step_i | input | 1 | Step request; its rising edge advances the position |
| dir_i | input | 1 | 1 = clockwise, 0 = counter-clockwise |
| half_i | input | 1 | 1 = half-step mode, 0 = full-step mode |
| hold_idle_i | input | 1 | Idle-coil treatment in odd positions: 1 = high sides on, 0 = floating |
| set_i | input | 1 | Synchronous return to index 0 |
| phase_o | output | 3 | Current position in half-step units |
| hs_o | output | 4 | High-side enable for each terminal |
| ls_o | output | 4 | Low-side enable for each terminal |

## Verification
The bench builds the block with `SYNC_STAGES`=2, which gives a latency of three edges from a step request to a new position. It also places a home request on exactly the edge where a step takes effect. The bench holds the step input high for several cycles to show that only its edge counts. It leaves the block on odd positions and then switches to full-step mode in both directions, so the snap-to-even case is covered.

// File: rtl/step_seq_pkg.sv
package step_seq_pkg;
  localparam int POS_W          = 3;
  localparam int NUM_POS        = 1 << POS_W;
  localparam int NUM_COILS      = 2;
  localparam int TERMS_PER_COIL = 2;
  localparam int NUM_TERMS      = NUM_COILS * TERMS_PER_COIL;

  typedef logic [POS_W-1:0] pos_t;

  typedef enum logic [1:0] {
    DRV_OFF = 2'd0,
    DRV_FWD = 2'd1,
    DRV_REV = 2'd2
  } coil_drv_e;

  // polarity of one coil at a half-step position
  function automatic coil_drv_e coil_map(pos_t p, int unsigned coil);
    coil_drv_e d;
    d = DRV_OFF;
    if (coil == 0) begin
      unique case (p)
        3'd0, 3'd6, 3'd7: d = DRV_FWD;
        3'd2, 3'd3, 3'd4: d = DRV_REV;
        default:          d = DRV_OFF;
      endcase
    end else begin
      unique case (p)
        3'd0, 3'd1, 3'd2: d = DRV_FWD;
        3'd4, 3'd5, 3'd6: d = DRV_REV;
        default:          d = DRV_OFF;
      endcase
    end
    return d;
  endfunction
endpackage

// File: rtl/step_edge.sv
module step_edge #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic step_i,
  output logic pulse_o
);
  logic sampled;
  logic prev_q;

  generate
    if (SYNC_STAGES == 0) begin : g_direct
      assign sampled = step_i;
    end else begin : g_sync
      logic [SYNC_STAGES-1:0] sync_q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) sync_q <= '0;
        else if (SYNC_STAGES == 1) sync_q <= step_i;
        else sync_q <= {sync_q[SYNC_STAGES-2:0], step_i};
      end
      assign sampled = sync_q[SYNC_STAGES-1];
    end
  endgenerate

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= 1'b0;
    else         prev_q <= sampled;
  end

  assign pulse_o = sampled & ~prev_q;
endmodule

// File: rtl/step_pos.sv
module step_pos
  import step_seq_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic adv_i,
  input  logic set_i,
  input  logic cw_i,
  input  logic half_i,
  output pos_t pos_o
);
  pos_t pos_q;
  pos_t delta;
  pos_t pos_nxt;

  // odd position in full mode: single step snaps to even
  always_comb begin
    delta   = (half_i || pos_q[0]) ? pos_t'(1) : pos_t'(2);
    pos_nxt = cw_i ? pos_t'(pos_q + delta) : pos_t'(pos_q - delta);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    pos_q <= '0;
    else if (set_i) pos_q <= '0;
    else if (adv_i) pos_q <= pos_nxt;
  end

  assign pos_o = pos_q;
endmodule

// File: rtl/coil_drive.sv
module coil_drive
  import step_seq_pkg::*;
(
  input  coil_drv_e                 drv_i,
  input  logic                      hold_i,
  output logic [TERMS_PER_COIL-1:0] hs_o,
  output logic [TERMS_PER_COIL-1:0] ls_o
);
  always_comb begin
    hs_o = '0;
    ls_o = '0;
    unique case (drv_i)
      DRV_FWD: begin hs_o = 2'b01; ls_o = 2'b10; end
      DRV_REV: begin hs_o = 2'b10; ls_o = 2'b01; end
      default: begin hs_o = hold_i ? 2'b11 : 2'b00; ls_o = 2'b00; end
    endcase
  end
endmodule

// File: rtl/step_seq_top.sv
module step_seq_top
  import step_seq_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 step_i,
  input  logic                 dir_i,
  input  logic                 half_i,
  input  logic                 hold_idle_i,
  input  logic                 set_i,
  output logic [POS_W-1:0]     phase_o,
  output logic [NUM_TERMS-1:0] hs_o,
  output logic [NUM_TERMS-1:0] ls_o
);
  logic step_pulse;
  pos_t pos;

  step_edge #(.SYNC_STAGES(SYNC_STAGES)) u_edge (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .step_i (step_i),
    .pulse_o(step_pulse)
  );

  step_pos u_pos (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .adv_i (step_pulse),
    .set_i (set_i),
    .cw_i  (dir_i),
    .half_i(half_i),
    .pos_o (pos)
  );

  generate
    for (genvar c = 0; c < NUM_COILS; c++) begin : g_coil
      coil_drv_e drv;
      always_comb drv = coil_map(pos, c);
      coil_drive u_drv (
        .drv_i (drv),
        .hold_i(hold_idle_i),
        .hs_o  (hs_o[c*TERMS_PER_COIL +: TERMS_PER_COIL]),
        .ls_o  (ls_o[c*TERMS_PER_COIL +: TERMS_PER_COIL])
      );
    end
  endgenerate

  assign phase_o = pos;
endmodule

// File: rtl/step_seq_chk.sv
module step_seq_chk
  import step_seq_pkg::*;
(
  input logic                 clk_i,
  input logic                 rst_ni,
  input logic                 step_pulse,
  input logic                 set_i,
  input logic                 half_i,
  input logic                 hold_idle_i,
  input logic [POS_W-1:0]     phase_o,
  input logic [NUM_TERMS-1:0] hs_o,
  input logic [NUM_TERMS-1:0] ls_o
);
  p_no_overlap_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hs_o & ls_o) == '0);

  p_set_home_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    set_i |=> phase_o == '0);

  p_hold_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!step_pulse && !set_i) |=> $stable(phase_o));

  p_move_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step_pulse && !set_i) |=> phase_o != $past(phase_o));

  p_half_unit_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step_pulse && !set_i && half_i) |=>
      (POS_W'(phase_o - $past(phase_o)) == POS_W'(1) ||
       POS_W'($past(phase_o) - phase_o) == POS_W'(1)));

  p_full_even_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step_pulse && !set_i && !half_i) |=> !phase_o[0]);

  p_both_coils_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !phase_o[0] |-> ($countones(hs_o) == 2 && $countones(ls_o) == 2));

  p_float_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase_o[0] && !hold_idle_i) |-> ($countones(hs_o) == 1 && $countones(ls_o) == 1));

  p_idle_high_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase_o[0] && hold_idle_i) |-> ($countones(hs_o) == 3 && $countones(ls_o) == 1));
endmodule

bind step_seq_top step_seq_chk u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .step_pulse (step_pulse),
  .set_i      (set_i),
  .half_i     (half_i),
  .hold_idle_i(hold_idle_i),
  .phase_o    (phase_o),
  .hs_o       (hs_o),
  .ls_o       (ls_o)
);

// File: tb/sim_step_seq_top.sv
module sim_step_seq_top;
  localparam int CLK_PERIOD = 10;
  localparam int SYNC = 2;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       step = 1'b0, dir = 1'b1, half = 1'b0, hold = 1'b0, set = 1'b0;
  logic [2:0] phase;
  logic [3:0] hs, ls;

  int    total = 0;
  int    bad = 0;
  int    m_pos = 0;
  bit    run_cmp = 1'b0;
  bit    done = 1'b0;
  string cur_req = "R1";

  always #(CLK_PERIOD/2) clk = ~clk;

  step_seq_top #(.SYNC_STAGES(SYNC)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .step_i(step), .dir_i(dir), .half_i(half),
    .hold_idle_i(hold), .set_i(set), .phase_o(phase), .hs_o(hs), .ls_o(ls)
  );

  function automatic logic [3:0] exp_hs(int p, bit h);
    case (p)
      0: return 4'b0101;
      1: return h ? 4'b0111 : 4'b0100;
      2: return 4'b0110;
      3: return h ? 4'b1110 : 4'b0010;
      4: return 4'b1010;
      5: return h ? 4'b1011 : 4'b1000;
      6: return 4'b1001;
      default: return h ? 4'b1101 : 4'b0001;
    endcase
  endfunction

  function automatic logic [3:0] exp_ls(int p);
    case (p)
      0: return 4'b1010;
      1: return 4'b1000;
      2: return 4'b1001;
      3: return 4'b0001;
      4: return 4'b0101;
      5: return 4'b0100;
      6: return 4'b0110;
      default: return 4'b0010;
    endcase
  endfunction

  task automatic check(string req, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual=%0h expected=%0h (t=%0t)", req, act, exp, $time);
    end
  endtask

  function automatic string drv_req();
    if (m_pos % 2 == 0) return "R7";
    return hold ? "R9" : "R8 R9";
  endfunction

  // compare on every clock, a quarter period after the edge
  always @(posedge clk) begin
    #(CLK_PERIOD/4);
    if (run_cmp && rst_n) begin
      check(cur_req, int'(phase), m_pos);
      check(drv_req(), int'(hs), int'(exp_hs(m_pos, hold)));
      check(drv_req(), int'(ls), int'(exp_ls(m_pos)));
      check("R10", int'(hs & ls), 0);
    end
  end

  function automatic void model_step();
    int d;
    d = dir ? 1 : -1;
    if (half || (m_pos % 2 == 1)) m_pos = (m_pos + d + 8) % 8;
    else                          m_pos = (m_pos + 2*d + 8) % 8;
  endfunction

  task automatic do_step();
    @(negedge clk) step = 1'b1;
    repeat (SYNC+1) @(posedge clk);
    model_step();
    repeat (2) @(negedge clk);
    step = 1'b0;
    repeat (SYNC+2) @(negedge clk);
  endtask

  task automatic do_set();
    @(negedge clk) set = 1'b1;
    @(posedge clk) m_pos = 0;
    @(negedge clk) set = 1'b0;
  endtask

  task automatic set_on_step();
    @(negedge clk) step = 1'b1;
    repeat (SYNC) @(posedge clk);
    @(negedge clk) set = 1'b1;
    @(posedge clk) m_pos = 0;
    @(negedge clk) begin set = 1'b0; step = 1'b0; end
    repeat (SYNC+2) @(negedge clk);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog: actual=hung expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1", int'(phase), 0);
    check("R1", int'(hs), 4'b0101);
    check("R1", int'(ls), 4'b1010);
    run_cmp = 1'b1;

    cur_req = "R2";
    repeat (6) @(negedge clk);
    do_step();

    cur_req = "R4";
    dir = 1'b1;
    for (int i = 0; i < 5; i++) do_step();
    cur_req = "R3";
    dir = 1'b0;
    for (int i = 0; i < 3; i++) do_step();

    cur_req = "R5";
    half = 1'b1;
    dir = 1'b1;
    for (int i = 0; i < 9; i++) do_step();
    cur_req = "R9";
    @(negedge clk) hold = 1'b1;
    dir = 1'b0;
    for (int i = 0; i < 4; i++) do_step();
    @(negedge clk) hold = 1'b0;
    do_step();

    cur_req = "R11";
    do_set();
    do_step();
    set_on_step();
    repeat (3) @(negedge clk);

    cur_req = "R6";
    dir = 1'b1;
    do_step();
    @(negedge clk) half = 1'b0;
    do_step();
    @(negedge clk) half = 1'b1;
    do_step();
    @(negedge clk) begin half = 1'b0; dir = 1'b0; end
    do_step();
    @(negedge clk) half = 1'b1;
    do_step();
    @(negedge clk) half = 1'b0;
    do_step();
    do_step();

    cur_req = "R2";
    repeat (5) @(negedge clk);
    run_cmp = 1'b0;
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule